// File: doc/BRIEF.md
# Prescaler-Tapped Windowed Watchdog

This block is a reset watchdog whose count events come from a free-running binary time-base counter instead of from raw clocks. The time-base advances once per system clock. A two-bit interval code picks one of four time-base stages, and the carry out of that stage is the watchdog's count clock. A 2-bit watchdog counter records those carries. If software lets the window expire, the block emits a one-cycle reset request and stops itself. The reset window runs from 3.5 to 4.5 periods of the chosen count clock, measured from the last clear.

Software writes a three-bit control word. Bit 2 is the run/clear bit and bits [1:0] are the interval code. If the watchdog is stopped, writing bit 2 = 1 starts it and fixes the interval code. Once it is running, the same write only restarts the window. Only a power-on reset or the watchdog's own reset can stop it. Several events clear the counter and leave it running: an external-pin reset, a software reset, or a sleep or stop entry strobe. The time-base also has its own clear input. That clear produces no count event, so it can stretch the real time to a watchdog reset.

Top module: `tapwd_watchdog`

## Requirements
- R1: While `por` is high and after it falls, the watchdog is stopped and `wdt_rst` stays 0 for any number of cycles, however many count events occur, until a start write is accepted.
- R2: A write with `wr_data[2]`=1 while stopped starts the watchdog and captures `wr_data[1:0]` as the interval code; a write with `wr_data[2]`=0 has no effect, stopped or running.
- R3: Interval code c selects count period P = 2^LOG_Pc cycles; with the time-base value v during the cycle of an accepted start or clear, the pulse appears after edge d + 3P + P/2 counted from the accepting edge, where d = ((P-2-(v mod P)) mod P) + 1, which lies in (3.5P, 4.5P].
- R4: A write with `wr_data[2]`=1 while running clears the counter and restarts the window; its `wr_data[1:0]` is ignored and the captured code stays in use.
- R5: A one-cycle pulse on `pin_rst`, `sw_rst`, `sleep_enter` or `stop_enter` while running restarts the window as in R3, and the watchdog stays running.
- R6: `wdt_rst` is high for exactly one cycle, and the watchdog is stopped afterwards: no further pulse occurs until a new start write.
- R7: `por` while running stops the watchdog, and no pulse follows.
- R8: A clear in the same cycle as a count event or as the firing event wins: the counter ends at 0 and no pulse is produced in that cycle.
- R9: `tb_clr` zeroes the time-base and produces no count event. With repeated clears the watchdog never fires, and after the last clear it fires 4.5P cycles later when no event had been counted.
- R10: Once running, the watchdog stays running, and its interval code stays constant until `por` or its own pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the time-base increment |
| por | input | 1 | Synchronous active-high power-on reset |
| pin_rst | input | 1 | External-pin reset event (clears counter) |
| sw_rst | input | 1 | Software reset event (clears counter) |
| sleep_enter | input | 1 | Sleep mode entry strobe (clears counter) |
| stop_enter | input | 1 | Stop mode entry strobe (clears counter) |
| tb_clr | input | 1 | Clears the time-base counter |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 3 | [2] run/clear, [1:0] interval code |
| wdt_rst | output | 1 | One-cycle watchdog reset request |

## Verification
A clear can arrive in the same cycle as a count carry. It can also arrive in the same cycle as the mid-period event that would fire the reset. The bench starts the watchdog at a known time-base phase and computes, from the R3 formula, the edge at which each of those events falls. It then places a clear write exactly on that edge. It judges the outcome by the edge at which the pulse finally appears: it must be counted from the clear, with no early pulse and no missed count.

// File: rtl/tapwd_pkg.sv
package tapwd_pkg;
  localparam int unsigned NUM_TAPS = 4;
  localparam int unsigned SEL_W    = 2;
  localparam int unsigned CNT_W    = 2;
  localparam int unsigned WR_W     = 3;

  typedef logic [SEL_W-1:0] tap_sel_t;
  typedef logic [CNT_W-1:0] wd_cnt_t;

  typedef struct packed {
    logic     run;
    tap_sel_t sel;
  } wr_word_t;

  localparam wd_cnt_t CNT_LAST = {CNT_W{1'b1}};
endpackage

// File: rtl/tapwd_timebase.sv
module tapwd_timebase #(
  parameter int unsigned LOG_P0 = 12,
  parameter int unsigned LOG_P1 = 14,
  parameter int unsigned LOG_P2 = 16,
  parameter int unsigned LOG_P3 = 19
) (
  input  logic                          clk,
  input  logic                          por,
  input  logic                          clr,
  output logic [tapwd_pkg::NUM_TAPS-1:0] tick_full,
  output logic [tapwd_pkg::NUM_TAPS-1:0] tick_half
);
  import tapwd_pkg::*;

  localparam int unsigned TB_W = LOG_P3;

  function automatic int unsigned tap_log(input int unsigned g);
    case (g)
      0:       return LOG_P0;
      1:       return LOG_P1;
      2:       return LOG_P2;
      default: return LOG_P3;
    endcase
  endfunction

  logic [TB_W-1:0] tb_q;

  always_ff @(posedge clk) begin
    if (por || clr) tb_q <= '0;
    else            tb_q <= tb_q + 1'b1;
  end

  // Per tap: full carry when all lower bits of the period are ones,
  // half event when the tap's top bit is about to rise.
  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    localparam int unsigned LP = tap_log(g);
    logic full_c, half_c;
    assign full_c = &tb_q[LP-1:0];
    assign half_c = (&tb_q[LP-2:0]) & ~tb_q[LP-1];
    assign tick_full[g] = full_c & ~clr;
    assign tick_half[g] = half_c & ~clr;
  end
endmodule

// File: rtl/tapwd_core.sv
module tapwd_core
  import tapwd_pkg::*;
(
  input  logic                clk,
  input  logic                por,
  input  logic                clr_evt,
  input  logic                wr_en,
  input  wr_word_t            wr_word,
  input  logic [NUM_TAPS-1:0] tick_full,
  input  logic [NUM_TAPS-1:0] tick_half,
  output logic                active_o,
  output tap_sel_t            sel_o,
  output logic                wdt_rst_o
);
  logic     active_q, armed_q, rst_q;
  tap_sel_t sel_q;
  wd_cnt_t  cnt_q;

  logic run_wr, start, restart, tick, half;

  assign run_wr  = wr_en & wr_word.run;
  assign start   = ~active_q & run_wr;
  assign restart = active_q & (run_wr | clr_evt);
  assign tick    = tick_full[sel_q];
  assign half    = tick_half[sel_q];

  always_ff @(posedge clk) begin
    if (por) begin
      active_q <= 1'b0;
      armed_q  <= 1'b0;
      rst_q    <= 1'b0;
      sel_q    <= '0;
      cnt_q    <= '0;
    end else begin
      rst_q <= 1'b0;
      if (start) begin
        active_q <= 1'b1;
        sel_q    <= wr_word.sel;
        cnt_q    <= '0;
        armed_q  <= 1'b0;
      end else if (active_q) begin
        if (restart) begin
          cnt_q   <= '0;
          armed_q <= 1'b0;
        end else if (armed_q && half) begin
          rst_q    <= 1'b1;
          active_q <= 1'b0;
          cnt_q    <= '0;
          armed_q  <= 1'b0;
        end else if (tick) begin
          if (cnt_q == CNT_LAST) armed_q <= 1'b1;
          else                   cnt_q   <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign active_o  = active_q;
  assign sel_o     = sel_q;
  assign wdt_rst_o = rst_q;
endmodule

// File: rtl/tapwd_watchdog.sv
module tapwd_watchdog #(
  parameter int unsigned LOG_P0 = 12,
  parameter int unsigned LOG_P1 = 14,
  parameter int unsigned LOG_P2 = 16,
  parameter int unsigned LOG_P3 = 19
) (
  input  logic       clk,
  input  logic       por,
  input  logic       pin_rst,
  input  logic       sw_rst,
  input  logic       sleep_enter,
  input  logic       stop_enter,
  input  logic       tb_clr,
  input  logic       wr_en,
  input  logic [2:0] wr_data,
  output logic       wdt_rst
);
  import tapwd_pkg::*;

  logic [NUM_TAPS-1:0] tick_full, tick_half;
  logic                clr_evt;
  logic                core_active;
  tap_sel_t            core_sel;
  wr_word_t            wr_word;

  assign clr_evt = pin_rst | sw_rst | sleep_enter | stop_enter;
  assign wr_word = wr_word_t'(wr_data);

  tapwd_timebase #(
    .LOG_P0(LOG_P0), .LOG_P1(LOG_P1), .LOG_P2(LOG_P2), .LOG_P3(LOG_P3)
  ) u_tb (
    .clk      (clk),
    .por      (por),
    .clr      (tb_clr),
    .tick_full(tick_full),
    .tick_half(tick_half)
  );

  tapwd_core u_core (
    .clk      (clk),
    .por      (por),
    .clr_evt  (clr_evt),
    .wr_en    (wr_en),
    .wr_word  (wr_word),
    .tick_full(tick_full),
    .tick_half(tick_half),
    .active_o (core_active),
    .sel_o    (core_sel),
    .wdt_rst_o(wdt_rst)
  );
endmodule

// File: rtl/tapwd_watchdog_chk.sv
module tapwd_watchdog_chk (
  input logic       clk,
  input logic       por,
  input logic       pin_rst,
  input logic       sw_rst,
  input logic       sleep_enter,
  input logic       stop_enter,
  input logic       wr_en,
  input logic [2:0] wr_data,
  input logic       wdt_rst,
  input logic       active,
  input logic [1:0] sel
);
  logic clr_any;
  assign clr_any = pin_rst | sw_rst | sleep_enter | stop_enter | (wr_en & wr_data[2]);

  // R1: power-on reset leaves the block stopped and quiet
  a_r1_por_quiet: assert property (@(posedge clk)
    por |=> (!wdt_rst && !active));

  // R2: a start write takes effect with the written code
  a_r2_start: assert property (@(posedge clk) disable iff (por)
    (!active && wr_en && wr_data[2]) |=> (active && sel == $past(wr_data[1:0])));

  // R6: single-cycle pulse
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (por)
    wdt_rst |=> !wdt_rst);

  // R6: the pulse coincides with the stopped state
  a_r6_stops_on_fire: assert property (@(posedge clk) disable iff (por)
    wdt_rst |-> !active);

  // R8: a clear in any cycle suppresses a pulse in the next
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (por)
    clr_any |=> !wdt_rst);

  // R10: once running, only its own pulse stops it
  a_r10_stays_active: assert property (@(posedge clk) disable iff (por)
    active |=> (active || wdt_rst));

  // R4 / R10: the interval code is frozen while running
  a_r4_sel_frozen: assert property (@(posedge clk) disable iff (por)
    active |=> $stable(sel));
endmodule

bind tapwd_watchdog tapwd_watchdog_chk u_chk (
  .clk        (clk),
  .por        (por),
  .pin_rst    (pin_rst),
  .sw_rst     (sw_rst),
  .sleep_enter(sleep_enter),
  .stop_enter (stop_enter),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .wdt_rst    (wdt_rst),
  .active     (core_active),
  .sel        (core_sel)
);

// File: tb/tapwd_watchdog_tb.sv
`timescale 1ns/1ps
module tapwd_watchdog_tb;
  localparam int LP0 = 3, LP1 = 4, LP2 = 5, LP3 = 6;
  localparam int TBW = LP3;

  logic clk = 1'b0;
  logic por = 1'b1;
  logic pin_rst = 0, sw_rst = 0, sleep_enter = 0, stop_enter = 0, tb_clr = 0;
  logic wr_en = 0;
  logic [2:0] wr_data = '0;
  logic wdt_rst;
  logic [TBW-1:0] tbm;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tapwd_watchdog #(.LOG_P0(LP0), .LOG_P1(LP1), .LOG_P2(LP2), .LOG_P3(LP3)) u_dut (
    .clk(clk), .por(por), .pin_rst(pin_rst), .sw_rst(sw_rst),
    .sleep_enter(sleep_enter), .stop_enter(stop_enter), .tb_clr(tb_clr),
    .wr_en(wr_en), .wr_data(wr_data), .wdt_rst(wdt_rst)
  );

  // time-base model: increments every clock, zeroed by por or tb_clr
  always @(posedge clk) tbm <= (por || tb_clr) ? '0 : tbm + 1'b1;

  function automatic int lp_of(input int c);
    case (c)
      0: return LP0;
      1: return LP1;
      2: return LP2;
      default: return LP3;
    endcase
  endfunction

  function automatic int exp_lat(input int v, input int c);
    int p, vm, d;
    p  = 1 << lp_of(c);
    vm = v % p;
    d  = ((p - 2 - vm) % p + p) % p + 1;
    return d + 3 * p + p / 2;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Drive one event kind for one cycle starting at the current negedge.
  task automatic drive_ev(input int kind, input logic [2:0] wd);
    case (kind)
      1: pin_rst = 1;
      2: sw_rst = 1;
      3: sleep_enter = 1;
      4: stop_enter = 1;
      5: begin wr_en = 1; wr_data = wd; end
      6: por = 1;
      default: ;
    endcase
  endtask

  task automatic release_ev();
    pin_rst = 0; sw_rst = 0; sleep_enter = 0; stop_enter = 0;
    wr_en = 0; por = 0;
  endtask

  // Start write at this negedge; optional event at observation index ev_at.
  // k = edge (from the start edge) after which the pulse was seen, or limit.
  task automatic go(input logic [2:0] wd, input int kind, input int ev_at,
                    input logic [2:0] ev_wd, input int limit,
                    output int k, output int v0, output int vev);
    wr_en = 1; wr_data = wd; v0 = int'(tbm); vev = 0;
    @(negedge clk);
    wr_en = 0;
    k = 0;
    while (!wdt_rst && k < limit) begin
      if (kind != 0 && k == ev_at) begin
        drive_ev(kind, ev_wd);
        vev = int'(tbm);
      end
      @(negedge clk);
      release_ev();
      k++;
    end
  endtask

  task automatic wait_phase(input int p, input int ph);
    while ((int'(tbm) % p) != ph) @(negedge clk);
  endtask

  task automatic quiet(input int n, input string req);
    int seen;
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wdt_rst) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  initial begin
    int k, v0, vev, p, e;
    repeat (3) @(negedge clk);
    chk(wdt_rst == 1'b0, "R1 during por", int'(wdt_rst), 0);
    por = 0;
    quiet(600, "R1 stopped after por");

    // R2: write with run bit clear does nothing while stopped
    wr_en = 1; wr_data = 3'b011;
    @(negedge clk); wr_en = 0;
    quiet(600, "R2 run=0 ignored when stopped");

    // R3/R6: sweep every code and every time-base phase
    for (int c = 0; c < 4; c++) begin
      p = 1 << lp_of(c);
      for (int ph = 0; ph < p; ph++) begin
        wait_phase(p, ph);
        go({1'b1, 2'(c)}, 0, 0, 3'b0, 10 * p, k, v0, vev);
        e = exp_lat(v0, c);
        chk(k == e, "R3 latency", k, e);
        chk(k * 2 > 7 * p && k * 2 <= 9 * p, "R3 window", k, e);
        @(negedge clk);
        chk(wdt_rst == 1'b0, "R6 pulse width", int'(wdt_rst), 0);
        if (ph == 0) quiet(5 * p, "R6 stopped after fire");
      end
    end

    // R5: each clearing event restarts the window and keeps running
    p = 1 << LP1;
    for (int kind = 1; kind <= 4; kind++) begin
      go(3'b101, kind, 2 * p + kind, 3'b0, 20 * p, k, v0, vev);
      e = 2 * p + kind + 1 + exp_lat(vev, 1);
      chk(k == e, "R5 clear event restarts", k, e);
    end

    // R4: running write with other code clears but code is kept
    p = 1 << LP0;
    go(3'b100, 5, 2 * p, 3'b111, 20 * p, k, v0, vev);
    e = 2 * p + 1 + exp_lat(vev, 0);
    chk(k == e, "R4 select ignored while running", k, e);

    // R2: run=0 write while running has no effect
    go(3'b100, 5, 2 * p, 3'b011, 20 * p, k, v0, vev);
    e = exp_lat(v0, 0);
    chk(k == e, "R2 run=0 ignored when running", k, e);

    // R8: clear in the same cycle as a count carry
    wait_phase(p, 0);
    go(3'b100, 5, 2 * p - 2, 3'b100, 20 * p, k, v0, vev);
    chk(vev % p == p - 1, "R8 clear on carry cycle", vev % p, p - 1);
    e = 2 * p - 1 + exp_lat(vev, 0);
    chk(k == e, "R8 clear beats carry", k, e);

    // R8: clear in the same cycle as the firing event
    wait_phase(p, 0);
    e = exp_lat(0, 0);
    go(3'b100, 5, e - 1, 3'b100, 20 * p, k, v0, vev);
    chk(vev % p == p / 2 - 1, "R8 clear on fire cycle", vev % p, p / 2 - 1);
    e = e + exp_lat(vev, 0);
    chk(k == e, "R8 clear beats fire", k, e);

    // R7: por while running stops the watchdog
    go(3'b100, 6, p, 3'b0, 8 * p, k, v0, vev);
    chk(k == 8 * p, "R7 por stops running watchdog", k, 8 * p);

    // R9: repeated time-base clears hold off the reset
    wr_en = 1; wr_data = 3'b100; tb_clr = 1;
    @(negedge clk);
    wr_en = 0; tb_clr = 0;
    k = 0;
    for (int i = 0; i < 100; i++) begin
      tb_clr = (i % 4 == 2);
      @(negedge clk);
      if (wdt_rst) k++;
    end
    tb_clr = 1;
    @(negedge clk);
    tb_clr = 0;
    chk(k == 0, "R9 no fire under tb clears", k, 0);
    k = 0;
    while (!wdt_rst && k < 20 * p) begin
      @(negedge clk);
      k++;
    end
    e = 4 * p + p / 2;
    chk(k == e, "R9 fire after last tb clear", k, e);

    done = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule